// File: doc/BRIEF.md
# PC-Indexed Way Predictor

This block runs beside the tag lookup of a four-way set-associative cache. When a load presents its program counter, set index and tag, the block reads a small table addressed by bits of the program counter and names, in the same cycle, the way the load is expected to hit. The data array can steer that way's data onward early, without waiting for the tag comparison. At the same time the block issues a read to the tag array for the addressed set.

One cycle later the tags and valid bits of all ways come back. The block compares every way against the load's tag and reports one of three outcomes. The guess was right. The guess was wrong but another way hit, which is a way-miss: the load must be replayed and the table entry is retrained to the way that hit. Or no way holds the line, which is a real cache miss and leaves the table alone. Refill and the data array belong to other blocks.

Control is a two-state machine. PH_IDLE means no lookup is awaiting verification. PH_VERIFY means the tag data returning this cycle belongs to the previous lookup. The transition IDLE→VERIFY, and also VERIFY→VERIFY, is taken on any cycle with a lookup. VERIFY→IDLE is taken on a cycle without one. IDLE→IDLE covers idle cycles.

Top module: `way_predictor`

## Requirements
- R1: After reset every one of the 64 table entries predicts way 0, and `res_valid` is low with `res_status` equal to 0.
- R2: `pred_way` is combinational and equals the table entry at index `lk_pc[7:2]` (table index = PC bits starting at bit 2, six bits wide).
- R3: In the cycle of a lookup (`lk_valid`=1), `tag_rd_en` is 1 and `tag_rd_set` equals `lk_set`. In the next cycle exactly, `res_valid` is 1 and `res_status` is nonzero. Way w's tag is on `tag_rd_tags[w*20 +: 20]` and its valid bit is on `tag_rd_vld[w]`.
- R4: If the predicted way is valid and its tag equals the lookup tag, `res_status` is 1 (correct) and `res_hit_way` is the predicted way.
- R5: If the predicted way does not match but some other valid way does, `res_status` is 2 (way-miss, replay) and never 3. `res_hit_way` is the matching way.
- R6: After a way-miss, the entry at that load's index is rewritten to the hit way. The write lands at the clock edge that ends the result cycle. A lookup in the result cycle itself still sees the old entry.
- R7: If no valid way matches, `res_status` is 3 (miss), `res_hit_way` is 0, and the table is not changed.
- R8: If several valid ways match and the predicted way is not among them, the lowest-numbered matching way is reported and trained. If the predicted way is among them, the result is correct.
- R9: A way whose valid bit is 0 never counts as a match, whatever tag it holds.
- R10: In a cycle following one without a lookup, `res_valid` is 0 and `res_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Program counter of the load |
| lk_set | input | 6 | Cache set index of the load |
| lk_tag | input | 20 | Address tag of the load |
| pred_way | output | 2 | Predicted way, same cycle |
| tag_rd_en | output | 1 | Tag-array read strobe |
| tag_rd_set | output | 6 | Set to read from the tag array |
| tag_rd_tags | input | 80 | Tags of all ways, one cycle after the read |
| tag_rd_vld | input | 4 | Valid bits of all ways, one cycle after the read |
| res_valid | output | 1 | Result present for the previous cycle's lookup |
| res_status | output | 2 | 0 none, 1 correct, 2 way-miss, 3 miss |
| res_hit_way | output | 2 | Way that actually hit (0 on miss) |

## Verification
A table entry holding a wrong way first shows on `pred_way` in the same cycle a load indexes it. It then shows one cycle later as a spurious status, a way-miss in place of a correct prediction or the reverse. A missed or misdirected retrain appears on the next load that uses the same index. The bench therefore keeps its own behavioural table and checks `pred_way` and the whole result every cycle. It also issues a lookup in the result cycle to the same index, which exposes any write landing one edge too early or too late.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_CORRECT = 2'd1,
        RES_WAYMISS = 2'd2,
        RES_MISS    = 2'd3
    } res_status_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_VERIFY = 1'b1
    } phase_e;

endpackage

// File: rtl/wp_table.sv
module wp_table #(
    parameter int DEPTH = 64,
    parameter int WAY_W = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WAY_W-1:0] rd_way,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WAY_W-1:0] wr_way
);

    logic [WAY_W-1:0] entry_q [DEPTH];

    // Every entry points to way 0 out of reset; one retrain per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                entry_q[i] <= '0;
            end
        end else if (wr_en) begin
            entry_q[wr_idx] <= wr_way;
        end
    end

    assign rd_way = entry_q[rd_idx];

endmodule

// File: rtl/wp_tag_match.sv
module wp_tag_match #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*TAG_W-1:0] way_tags,
    input  logic [NUM_WAYS-1:0]       way_vld,
    input  logic [TAG_W-1:0]          probe_tag,
    input  logic [WAY_W-1:0]          guess_way,
    output logic                      any_hit,
    output logic                      guess_hit,
    output logic [WAY_W-1:0]          first_way
);

    logic [NUM_WAYS-1:0] hit_vec;

    // One comparator per way; an invalid way can never hit.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_vld[w] &&
                            (way_tags[w*TAG_W +: TAG_W] == probe_tag);
    end

    assign any_hit   = |hit_vec;
    assign guess_hit = hit_vec[guess_way];

    // Lowest-numbered hitting way wins.
    always_comb begin
        first_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                first_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int WAY_W = 2,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [WAY_W-1:0] lk_pred,
    output logic [TAG_W-1:0] stg_tag,
    output logic [WAY_W-1:0] stg_pred,
    input  logic             any_hit,
    input  logic             guess_hit,
    input  logic [WAY_W-1:0] first_way,
    output logic             res_valid,
    output res_status_e      res_status,
    output logic [WAY_W-1:0] res_hit_way,
    output logic             upd_en,
    output logic [IDX_W-1:0] upd_idx,
    output logic [WAY_W-1:0] upd_way
);

    phase_e           state_q, state_d;
    logic [IDX_W-1:0] stg_idx_q;
    logic [TAG_W-1:0] stg_tag_q;
    logic [WAY_W-1:0] stg_pred_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   state_d = lk_valid ? PH_VERIFY : PH_IDLE;
            PH_VERIFY: state_d = lk_valid ? PH_VERIFY : PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Lookup context held for the verify cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_idx_q  <= '0;
            stg_tag_q  <= '0;
            stg_pred_q <= '0;
        end else if (lk_valid) begin
            stg_idx_q  <= lk_idx;
            stg_tag_q  <= lk_tag;
            stg_pred_q <= lk_pred;
        end
    end

    assign stg_tag  = stg_tag_q;
    assign stg_pred = stg_pred_q;
    assign upd_idx  = stg_idx_q;

    // Outputs per state.
    always_comb begin
        res_valid   = 1'b0;
        res_status  = RES_NONE;
        res_hit_way = '0;
        upd_en      = 1'b0;
        upd_way     = first_way;
        unique case (state_q)
            PH_IDLE: begin
                res_valid = 1'b0;
            end
            PH_VERIFY: begin
                res_valid = 1'b1;
                if (guess_hit) begin
                    res_status  = RES_CORRECT;
                    res_hit_way = stg_pred_q;
                end else if (any_hit) begin
                    res_status  = RES_WAYMISS;
                    res_hit_way = first_way;
                    upd_en      = 1'b1;
                end else begin
                    res_status  = RES_MISS;
                end
            end
            default: begin
                res_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/way_predictor.sv
module way_predictor
    import wp_pkg::*;
#(
    parameter int NUM_WAYS  = 4,
    parameter int TBL_DEPTH = 64,
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int SET_W     = 6,
    parameter int TAG_W     = 20,
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lk_valid,
    input  logic [PC_W-1:0]           lk_pc,
    input  logic [SET_W-1:0]          lk_set,
    input  logic [TAG_W-1:0]          lk_tag,
    output logic [WAY_W-1:0]          pred_way,
    output logic                      tag_rd_en,
    output logic [SET_W-1:0]          tag_rd_set,
    input  logic [NUM_WAYS*TAG_W-1:0] tag_rd_tags,
    input  logic [NUM_WAYS-1:0]       tag_rd_vld,
    output logic                      res_valid,
    output logic [1:0]                res_status,
    output logic [WAY_W-1:0]          res_hit_way
);

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] stg_tag;
    logic [WAY_W-1:0] stg_pred;
    logic             any_hit, guess_hit;
    logic [WAY_W-1:0] first_way;
    logic             upd_en;
    logic [IDX_W-1:0] upd_idx;
    logic [WAY_W-1:0] upd_way;
    res_status_e      status_e;

    assign lk_idx     = lk_pc[PC_LSB +: IDX_W];
    assign tag_rd_en  = lk_valid;
    assign tag_rd_set = lk_set;
    assign res_status = status_e;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{lk_pc};

    wp_table #(
        .DEPTH (TBL_DEPTH),
        .WAY_W (WAY_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_idx),
        .rd_way (pred_way),
        .wr_en  (upd_en),
        .wr_idx (upd_idx),
        .wr_way (upd_way)
    );

    wp_tag_match #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W)
    ) u_match (
        .way_tags  (tag_rd_tags),
        .way_vld   (tag_rd_vld),
        .probe_tag (stg_tag),
        .guess_way (stg_pred),
        .any_hit   (any_hit),
        .guess_hit (guess_hit),
        .first_way (first_way)
    );

    wp_ctrl #(
        .IDX_W (IDX_W),
        .WAY_W (WAY_W),
        .TAG_W (TAG_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_valid    (lk_valid),
        .lk_idx      (lk_idx),
        .lk_tag      (lk_tag),
        .lk_pred     (pred_way),
        .stg_tag     (stg_tag),
        .stg_pred    (stg_pred),
        .any_hit     (any_hit),
        .guess_hit   (guess_hit),
        .first_way   (first_way),
        .res_valid   (res_valid),
        .res_status  (status_e),
        .res_hit_way (res_hit_way),
        .upd_en      (upd_en),
        .upd_idx     (upd_idx),
        .upd_way     (upd_way)
    );

endmodule

// File: rtl/wp_checker.sv
module wp_checker
    import wp_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20,
    parameter int WAY_W    = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      lk_valid,
    input logic [TAG_W-1:0]          lk_tag,
    input logic [WAY_W-1:0]          pred_way,
    input logic [NUM_WAYS*TAG_W-1:0] tag_rd_tags,
    input logic [NUM_WAYS-1:0]       tag_rd_vld,
    input logic                      res_valid,
    input logic [1:0]                res_status,
    input logic [WAY_W-1:0]          res_hit_way
);

    logic [TAG_W-1:0] prev_tag;
    logic             seen_any;
    logic             seen_hit_way;

    always_ff @(posedge clk) begin
        prev_tag <= lk_tag;
    end

    always_comb begin
        seen_any     = 1'b0;
        seen_hit_way = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (tag_rd_vld[w] && tag_rd_tags[w*TAG_W +: TAG_W] == prev_tag) begin
                seen_any = 1'b1;
                if (WAY_W'(w) == res_hit_way) begin
                    seen_hit_way = 1'b1;
                end
            end
        end
    end

    p_result_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_valid && res_status != 2'(RES_NONE)));

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && res_status == 2'(RES_NONE)));

    p_correct_is_guess_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'(RES_CORRECT)) |->
            (res_hit_way == $past(pred_way) && seen_hit_way));

    p_waymiss_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'(RES_WAYMISS)) |->
            (res_hit_way != $past(pred_way) && seen_hit_way));

    p_hit_not_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && seen_any) |-> (res_status != 2'(RES_MISS)));

    p_miss_has_no_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'(RES_MISS)) |->
            (!seen_any && res_hit_way == '0));

endmodule

bind way_predictor wp_checker #(
    .NUM_WAYS (NUM_WAYS),
    .TAG_W    (TAG_W),
    .WAY_W    (WAY_W)
) u_wp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_tag      (lk_tag),
    .pred_way    (pred_way),
    .tag_rd_tags (tag_rd_tags),
    .tag_rd_vld  (tag_rd_vld),
    .res_valid   (res_valid),
    .res_status  (res_status),
    .res_hit_way (res_hit_way)
);

// File: tb/way_predictor_bench.sv
`timescale 1ns/1ps
module way_predictor_bench;

    localparam int NW   = 4;
    localparam int TW   = 20;
    localparam int SW   = 6;
    localparam int NTBL = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           lk_valid = 1'b0;
    logic [31:0]    lk_pc = '0;
    logic [SW-1:0]  lk_set = '0;
    logic [TW-1:0]  lk_tag = '0;
    logic [1:0]     pred_way;
    logic           tag_rd_en;
    logic [SW-1:0]  tag_rd_set;
    logic [NW*TW-1:0] tag_rd_tags = '0;
    logic [NW-1:0]  tag_rd_vld = '0;
    logic           res_valid;
    logic [1:0]     res_status;
    logic [1:0]     res_hit_way;

    always #2.5 clk = ~clk;

    way_predictor u_way_predictor (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_set(lk_set), .lk_tag(lk_tag), .pred_way(pred_way),
        .tag_rd_en(tag_rd_en), .tag_rd_set(tag_rd_set),
        .tag_rd_tags(tag_rd_tags), .tag_rd_vld(tag_rd_vld),
        .res_valid(res_valid), .res_status(res_status),
        .res_hit_way(res_hit_way)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Behavioural reference state.
    int  ref_tbl [NTBL];
    bit  ref_trained [NTBL];
    int  mem_tag [NTBL][NW];
    bit  mem_vld [NTBL][NW];
    bit  p_v = 1'b0;
    int  p_idx, p_set, p_tag, p_pred;

    function automatic int idx_of(input logic [31:0] pc);
        return int'((pc >> 2) & 32'd63);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_way(input int s, input int w, input bit v, input int t);
        mem_vld[s][w] = v;
        mem_tag[s][w] = t;
    endtask

    // One cycle: drive at negedge, compare at negedge+1, advance.
    task automatic step(input bit v, input logic [31:0] pc, input int set, input int tag);
        int cur_idx, cur_pred, nmatch, first, exp_st, exp_way;
        bit inval_alias;
        string lbl;
        cur_idx  = idx_of(pc);
        cur_pred = ref_tbl[cur_idx];
        lk_valid = v; lk_pc = pc; lk_set = SW'(set); lk_tag = TW'(tag);
        for (int w = 0; w < NW; w++) begin
            tag_rd_tags[w*TW +: TW] = TW'(mem_tag[p_set][w]);
            tag_rd_vld[w] = mem_vld[p_set][w];
        end
        #1;
        if (v) begin
            lbl = (p_v && p_idx == cur_idx) ? "R6" : (ref_trained[cur_idx] ? "R6" : "R2");
            check({lbl, " pred_way"}, int'(pred_way), cur_pred);
            check("R3 tag_rd_en", int'(tag_rd_en), 1);
            check("R3 tag_rd_set", int'(tag_rd_set), set);
        end
        if (p_v) begin
            nmatch = 0; first = -1; inval_alias = 1'b0;
            for (int w = 0; w < NW; w++) begin
                if (mem_vld[p_set][w] && mem_tag[p_set][w] == p_tag) begin
                    nmatch++;
                    if (first < 0) first = w;
                end
                if (!mem_vld[p_set][w] && mem_tag[p_set][w] == p_tag) inval_alias = 1'b1;
            end
            if (nmatch == 0) begin
                exp_st = 3; exp_way = 0; lbl = "R7";
            end else if (mem_vld[p_set][p_pred] && mem_tag[p_set][p_pred] == p_tag) begin
                exp_st = 1; exp_way = p_pred; lbl = "R4";
            end else begin
                exp_st = 2; exp_way = first; lbl = "R5";
            end
            if (nmatch > 1) lbl = "R8";
            else if (inval_alias) lbl = "R9";
            check("R3 res_valid", int'(res_valid), 1);
            check({lbl, " res_status"}, int'(res_status), exp_st);
            check({lbl, " res_hit_way"}, int'(res_hit_way), exp_way);
            if (exp_st == 2) begin
                ref_tbl[p_idx] = first;
                ref_trained[p_idx] = 1'b1;
            end
        end else begin
            check("R10 res_valid", int'(res_valid), 0);
            check("R10 res_status", int'(res_status), 0);
        end
        p_v = v; p_idx = cur_idx; p_set = set; p_tag = tag; p_pred = cur_pred;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, pb, pc3, pcs [16];
        for (int i = 0; i < NTBL; i++) begin
            ref_tbl[i] = 0;
            ref_trained[i] = 1'b0;
            for (int w = 0; w < NW; w++) begin
                mem_tag[i][w] = 100 + w;
                mem_vld[i][w] = 1'b1;
            end
        end
        p_set = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every entry and of the result port.
        for (int i = 0; i < NTBL; i++) begin
            lk_pc = 32'(i * 4);
            #0.1;
            check("R1 pred_way after reset", int'(pred_way), 0);
        end
        check("R1 res_valid", int'(res_valid), 0);
        check("R1 res_status", int'(res_status), 0);

        pa  = 32'h0000_1040;
        pb  = 32'h0000_2084;
        pc3 = 32'h0000_30C8;
        // Way-miss on way 2, retrain, then a correct guess.
        set_way(5, 2, 1'b1, 'hABC);
        step(1'b1, pa, 5, 'hABC);
        step(1'b1, pa, 5, 'hABC);   // result-cycle lookup sees old entry
        step(1'b1, pa, 5, 'hABC);
        step(1'b0, pa, 0, 0);
        // True miss leaves the table unchanged.
        step(1'b1, pa, 5, 'h777);
        step(1'b1, pa, 5, 'hABC);
        step(1'b0, 0, 0, 0);
        // Several matching ways, predicted way not among them.
        set_way(7, 1, 1'b1, 'h55); set_way(7, 3, 1'b1, 'h55);
        step(1'b1, pb, 7, 'h55);
        step(1'b1, pb, 7, 'h55);
        // Invalid way with a matching tag is ignored.
        set_way(9, 0, 1'b0, 'h66); set_way(9, 3, 1'b1, 'h66);
        step(1'b1, pc3, 9, 'h66);
        step(1'b1, pc3, 9, 'h66);
        set_way(9, 3, 1'b0, 'h66);
        step(1'b1, pc3, 9, 'h66);
        step(1'b0, 0, 0, 0);
        step(1'b0, 0, 0, 0);

        // Mixed traffic.
        for (int i = 0; i < 16; i++) pcs[i] = 32'(($urandom % 4096) * 4);
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 8 == 0) begin
                set_way(int'($urandom % 8), int'($urandom % 4),
                        1'($urandom % 4 != 0), int'($urandom % 5));
            end
            step(1'($urandom % 4 != 0), pcs[$urandom % 16],
                 int'($urandom % 8), int'($urandom % 5));
        end
        step(1'b0, 0, 0, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule